// File: doc/BRIEF.md
# Receive Destination Address Classifier

This block sorts each received frame by its destination address and decides whether the receive path should keep it. An upstream parser presents the 48-bit destination address, the 13-bit frame length, a 6-bit multicast hash index it has already computed, and the CRC and alignment error flags, all qualified by a one-cycle frame strobe. The block compares the address against the configured station address, looks the hash index up in a 64-bit multicast table, and checks the frame for errors. It then applies four accept enables: promiscuous unicast, broadcast, multicast and errored-frame.

One cycle after the strobe it presents a registered accept decision and a 16-bit receive status word. The low three bits of the status word carry a destination-type code. Error bits appear in the status word only when errored frames are being accepted. A two-state controller tracks whether a result is being reported. It has four transitions: IDLE to REPORT on a strobe (capture), REPORT to REPORT on a strobe in the next cycle (chain), REPORT to IDLE with no strobe (retire), and IDLE to IDLE with no strobe (wait).

Top module: `rx_dest_classifier`

## Requirements
- R1: A destination of all ones is broadcast and yields destination code 011 in status bits [2:0].
- R2: A non-broadcast destination with bit 40 set (bit 0 of the first byte sent) is multicast. It yields code 110 when `hash_table[hash_idx]` is 1 and code 010 when it is 0.
- R3: Any other destination is unicast. It yields code 001 when it equals `station_addr` and code 000 otherwise.
- R4: A broadcast frame is accepted only if `acc_bcast` is 1. A multicast frame is accepted only if `acc_mcast` is 1 and the hash bit is 1.
- R5: A unicast frame equal to `station_addr` is accepted whatever the enables are. Any other unicast frame is accepted only if `acc_phys_all` is 1.
- R6: A frame with a CRC error, an alignment error, or a length below 60 (runt) is rejected unless `acc_errored` is 1. With `acc_errored` set, the frame follows R4 and R5.
- R7: Status bit 6 flags a runt, bit 4 an alignment error and bit 3 a CRC error, each only while `acc_errored` is 1. Otherwise these bits read 0. Bits 15:7 and bit 5 always read 0.
- R8: `res_valid` is high in exactly the cycle after each cycle in which `frm_valid` is high, including back-to-back strobes.
- R9: With every hash table bit set to 1, every multicast frame is a hash hit.
- R10: After reset `res_valid`, `res_accept` and `res_status` are 0. Between strobes, `res_accept` and `res_status` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe qualifying the frame inputs |
| dst_addr | input | 48 | Destination address; bits 47:40 are the first byte sent |
| frm_len | input | 13 | Frame length in bytes |
| hash_idx | input | 6 | Multicast hash index computed upstream |
| err_crc | input | 1 | Frame failed its CRC check |
| err_align | input | 1 | Frame ended on a non-octet boundary |
| station_addr | input | 48 | Station unicast address |
| hash_table | input | 64 | Multicast hash filter, one bit per index |
| acc_phys_all | input | 1 | Accept every unicast frame |
| acc_bcast | input | 1 | Accept broadcast frames |
| acc_mcast | input | 1 | Accept multicast frames that hit the hash |
| acc_errored | input | 1 | Accept errored frames and report error bits |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Accept decision |
| res_status | output | 16 | Receive status word |

## Verification
The accept decision, the status word and the result strobe are all due in the cycle after the input strobe, because the design registers them at the same edge that samples the frame. The driver records, for each frame, the cycle number in which its result is due and pushes that number into the scoreboard with the expected values. The monitor samples on the falling edge. For every `res_valid` it pops one entry and checks that the current cycle equals the due cycle. A `res_valid` with nothing queued counts as a failure, and so does an entry left unretired at the end. A second check samples after idle cycles to confirm that the outputs hold.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [2:0] {
        DC_UNI_MISS = 3'b000,
        DC_UNI_HIT  = 3'b001,
        DC_MC_MISS  = 3'b010,
        DC_BCAST    = 3'b011,
        DC_MC_HIT   = 3'b110
    } dest_code_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rdc_state_e;

    localparam int ST_CRC_BIT  = 3;
    localparam int ST_ALN_BIT  = 4;
    localparam int ST_RUNT_BIT = 6;

endpackage

// File: rtl/rdc_addr_decode.sv
module rdc_addr_decode
    import rdc_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int HASH_IDX_W = 6,
    parameter int GROUP_BIT  = 40,
    localparam int HASH_N    = 1 << HASH_IDX_W
) (
    input  logic [ADDR_W-1:0]     dst_addr,
    input  logic [ADDR_W-1:0]     station_addr,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [HASH_N-1:0]     hash_table,
    output dest_code_e            code,
    output logic                  is_bcast,
    output logic                  is_mcast,
    output logic                  hash_hit,
    output logic                  own_hit
);
    always_comb begin
        is_bcast = &dst_addr;
        is_mcast = dst_addr[GROUP_BIT] && !is_bcast;
        hash_hit = hash_table[hash_idx];
        own_hit  = (dst_addr == station_addr);
        if (is_bcast)
            code = DC_BCAST;
        else if (is_mcast)
            code = hash_hit ? DC_MC_HIT : DC_MC_MISS;
        else
            code = own_hit ? DC_UNI_HIT : DC_UNI_MISS;
    end
endmodule

// File: rtl/rdc_error_check.sv
module rdc_error_check #(
    parameter int LEN_W   = 13,
    parameter int MIN_LEN = 60
) (
    input  logic [LEN_W-1:0] frm_len,
    input  logic             err_crc,
    input  logic             err_align,
    output logic             is_runt,
    output logic             any_err
);
    always_comb begin
        is_runt = (frm_len < LEN_W'(MIN_LEN));
        any_err = is_runt || err_crc || err_align;
    end
endmodule

// File: rtl/rx_dest_classifier.sv
module rx_dest_classifier
    import rdc_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LEN_W      = 13,
    parameter int HASH_IDX_W = 6,
    parameter int STAT_W     = 16,
    parameter int MIN_LEN    = 60,
    localparam int HASH_N    = 1 << HASH_IDX_W,
    localparam int GROUP_BIT = ADDR_W - 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frm_valid,
    input  logic [ADDR_W-1:0]     dst_addr,
    input  logic [LEN_W-1:0]      frm_len,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic                  err_crc,
    input  logic                  err_align,
    input  logic [ADDR_W-1:0]     station_addr,
    input  logic [HASH_N-1:0]     hash_table,
    input  logic                  acc_phys_all,
    input  logic                  acc_bcast,
    input  logic                  acc_mcast,
    input  logic                  acc_errored,
    output logic                  res_valid,
    output logic                  res_accept,
    output logic [STAT_W-1:0]     res_status
);
    dest_code_e code;
    logic       is_bcast, is_mcast, hash_hit, own_hit;
    logic       is_runt, any_err;
    logic       accept_d;
    logic [STAT_W-1:0] stat_d;
    rdc_state_e state_q, state_d;

    rdc_addr_decode #(
        .ADDR_W(ADDR_W), .HASH_IDX_W(HASH_IDX_W), .GROUP_BIT(GROUP_BIT)
    ) u_addr (
        .dst_addr(dst_addr), .station_addr(station_addr),
        .hash_idx(hash_idx), .hash_table(hash_table),
        .code(code), .is_bcast(is_bcast), .is_mcast(is_mcast),
        .hash_hit(hash_hit), .own_hit(own_hit)
    );

    rdc_error_check #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_err (
        .frm_len(frm_len), .err_crc(err_crc), .err_align(err_align),
        .is_runt(is_runt), .any_err(any_err)
    );

    // Accept policy and status assembly
    always_comb begin
        if (is_bcast)
            accept_d = acc_bcast;
        else if (is_mcast)
            accept_d = acc_mcast && hash_hit;
        else
            accept_d = own_hit || acc_phys_all;
        if (any_err && !acc_errored)
            accept_d = 1'b0;

        stat_d              = '0;
        stat_d[2:0]         = code;
        stat_d[ST_CRC_BIT]  = acc_errored && err_crc;
        stat_d[ST_ALN_BIT]  = acc_errored && err_align;
        stat_d[ST_RUNT_BIT] = acc_errored && is_runt;
    end

    // Next state: capture, chain, retire, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frm_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = frm_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept <= 1'b0;
            res_status <= '0;
        end else if (frm_valid) begin
            res_accept <= accept_d;
            res_status <= stat_d;
        end
    end

    assign res_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
    parameter int ADDR_W  = 48,
    parameter int LEN_W   = 13,
    parameter int STAT_W  = 16,
    parameter int MIN_LEN = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [ADDR_W-1:0] station_addr,
    input logic [LEN_W-1:0]  frm_len,
    input logic              err_crc,
    input logic              err_align,
    input logic              acc_bcast,
    input logic              acc_errored,
    input logic              res_valid,
    input logic              res_accept,
    input logic [STAT_W-1:0] res_status
);
    a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);

    a_r8_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);

    a_r4_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (&dst_addr) && !acc_bcast |=> !res_accept);

    a_r6_err_reject: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (err_crc || err_align) && !acc_errored |=> !res_accept);

    a_r5_own_accept: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (dst_addr == station_addr) && !station_addr[ADDR_W-8]
        && !err_crc && !err_align && (frm_len >= LEN_W'(MIN_LEN)) |=> res_accept);

    a_r7_err_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !acc_errored |=> (res_status[6:3] == 4'b0000));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_status[STAT_W-1:7] == '0) && !res_status[5]);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> $stable(res_accept) && $stable(res_status));
endmodule

bind rx_dest_classifier rdc_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAT_W(STAT_W), .MIN_LEN(MIN_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .dst_addr(dst_addr),
    .station_addr(station_addr), .frm_len(frm_len), .err_crc(err_crc),
    .err_align(err_align), .acc_bcast(acc_bcast), .acc_errored(acc_errored),
    .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
);

// File: tb/rx_dest_classifier_bench.sv
module rx_dest_classifier_bench;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_66;
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MCAST   = 48'h01_00_5E_00_00_01;

    typedef struct {
        logic        accept;
        logic [15:0] status;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [12:0] frm_len = '0;
    logic [5:0]  hash_idx = '0;
    logic        err_crc = 1'b0, err_align = 1'b0;
    logic [63:0] hash_table = 64'h0000_0000_0000_0020;
    logic        acc_phys_all = 1'b0, acc_bcast = 1'b0;
    logic        acc_mcast = 1'b0, acc_errored = 1'b0;
    logic        res_valid, res_accept;
    logic [15:0] res_status;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_dest_classifier u_rx_dest_classifier (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .dst_addr(dst_addr),
        .frm_len(frm_len), .hash_idx(hash_idx), .err_crc(err_crc),
        .err_align(err_align), .station_addr(STATION), .hash_table(hash_table),
        .acc_phys_all(acc_phys_all), .acc_bcast(acc_bcast),
        .acc_mcast(acc_mcast), .acc_errored(acc_errored),
        .res_valid(res_valid), .res_accept(res_accept), .res_status(res_status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected result from the requirements: bits [16]=accept, [15:0]=status
    function automatic logic [16:0] model(input logic [47:0] d, input logic [12:0] len,
                                          input logic [5:0] idx, input logic crc,
                                          input logic aln, input logic [3:0] acc);
        logic bc, mc, hit, own, runt, err, ok;
        logic [2:0]  code;
        logic [15:0] st;
        bc   = (d == BCAST);
        mc   = d[40] && !bc;
        hit  = hash_table[idx];
        own  = (d == STATION);
        code = bc ? 3'b011 : mc ? (hit ? 3'b110 : 3'b010) : (own ? 3'b001 : 3'b000);
        runt = (len < 13'd60);
        err  = runt || crc || aln;
        ok   = bc ? acc[1] : mc ? (acc[2] && hit) : (own || acc[0]);
        if (err && !acc[3]) ok = 1'b0;
        st = {9'b0, acc[3] && runt, 1'b0, acc[3] && aln, acc[3] && crc, code};
        return {ok, st};
    endfunction

    // acc = {errored, mcast, bcast, phys_all}
    task automatic drive(input string tag, input logic [47:0] d, input logic [12:0] len,
                         input logic [5:0] idx, input logic crc, input logic aln,
                         input logic [3:0] acc);
        exp_t e;
        logic [16:0] m;
        @(negedge clk);
        dst_addr = d; frm_len = len; hash_idx = idx;
        err_crc = crc; err_align = aln;
        {acc_errored, acc_mcast, acc_bcast, acc_phys_all} = acc;
        frm_valid = 1'b1;
        m = model(d, len, idx, crc, aln, acc);
        e.accept = m[16]; e.status = m[15:0]; e.due = cyc + 1; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected result", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    check({e.tag, " R8 due cycle"}, cyc, e.due);
                    check({e.tag, " accept"}, {31'b0, res_accept}, {31'b0, e.accept});
                    check({e.tag, " status"}, {16'b0, res_status}, {16'b0, e.status});
                end
            end
        end
    end

    initial begin
        logic        acc_keep;
        logic [15:0] st_keep;
        repeat (3) @(negedge clk);
        check("R10 reset valid",  {31'b0, res_valid}, 32'd0);
        check("R10 reset accept", {31'b0, res_accept}, 32'd0);
        check("R10 reset status", {16'b0, res_status}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        drive("R3 R5 own unicast no enables", STATION, 13'd64, 6'd0, 0, 0, 4'b0000); idle(2);
        drive("R3 other unicast rejected",    OTHER,   13'd64, 6'd0, 0, 0, 4'b0000); idle(2);
        drive("R5 promiscuous unicast",       OTHER,   13'd64, 6'd0, 0, 0, 4'b0001); idle(2);
        drive("R1 R4 broadcast disabled",     BCAST,   13'd64, 6'd0, 0, 0, 4'b0101); idle(2);
        drive("R1 R4 broadcast enabled",      BCAST,   13'd64, 6'd0, 0, 0, 4'b0010); idle(2);
        drive("R2 R4 multicast hash hit",     MCAST,   13'd64, 6'd5, 0, 0, 4'b0100); idle(2);
        drive("R2 R4 multicast hash miss",    MCAST,   13'd64, 6'd6, 0, 0, 4'b0100); idle(2);
        drive("R4 multicast disabled",        MCAST,   13'd64, 6'd5, 0, 0, 4'b0011); idle(2);
        drive("R6 R7 crc hidden",             STATION, 13'd64, 6'd0, 1, 0, 4'b0111); idle(2);
        drive("R6 R7 crc accepted",           STATION, 13'd64, 6'd0, 1, 0, 4'b1000); idle(2);
        drive("R6 runt len 59 rejected",      STATION, 13'd59, 6'd0, 0, 0, 4'b0000); idle(2);
        drive("R6 len 60 not runt",           STATION, 13'd60, 6'd0, 0, 0, 4'b0000); idle(2);
        drive("R7 runt and align reported",   STATION, 13'd59, 6'd0, 0, 1, 4'b1000); idle(2);
        drive("R6 errored promiscuous",       OTHER,   13'd10, 6'd0, 1, 1, 4'b1001); idle(2);

        // R8: back-to-back strobes
        drive("R8 chain first",  BCAST, 13'd100, 6'd0, 0, 0, 4'b0010);
        drive("R8 chain second", OTHER, 13'd100, 6'd0, 0, 0, 4'b0000);
        drive("R8 chain third",  MCAST, 13'd100, 6'd5, 0, 0, 4'b0100);
        idle(3);

        // R10: outputs hold while idle and inputs change
        acc_keep = res_accept; st_keep = res_status;
        dst_addr = BCAST; acc_bcast = 1'b1; err_crc = 1'b1;
        idle(3);
        check("R10 idle valid low", {31'b0, res_valid}, 32'd0);
        check("R10 accept held", {31'b0, res_accept}, {31'b0, acc_keep});
        check("R10 status held", {16'b0, res_status}, {16'b0, st_keep});

        // R9: all-ones hash table
        hash_table = '1;
        drive("R9 all-ones hash idx 6", MCAST, 13'd64, 6'd6, 0, 0, 4'b0100); idle(1);
        drive("R9 all-ones hash idx 63", 48'h33_33_00_00_00_01, 13'd64, 6'd63, 0, 0, 4'b0100);
        idle(4);

        check("R8 scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule